// File: doc/BRIEF.md
# Sector Error Correction Applier

This block sits behind a four-error-capable parity decoder for a 512-byte flash sector. Once the decoder has settled, the block takes its outcome and repairs the sector buffer in place. The decoder outcome consists of the stored parity bytes, a nonzero-syndrome flag, a status word, and two packed pairs of error locations and error values. The block reaches the buffer through a byte-wide port that reads and then writes back.

A one-cycle `start` pulse captures every input. The block then decides whether any repair is due. Two cases need no repair: a sector that was never programmed (all parity bytes erased) and a clean syndrome. A decoder that reports too many errors raises `failed`. In the correction states, each reported location is converted from its reversed form to a buffer offset. An offset that lands in the parity area is skipped. Each remaining byte is XORed with its error value. A one-cycle `done` pulse marks the end, and the number of bytes repaired stays on `fixedCount` until the next start.

Top module: `eccFixApply`

## Requirements
- R1: While reset is asserted and immediately after its release, `done`, `failed`, `fixedCount`, `bufRdEn` and `bufWrEn` are all zero.
- R2: When all ten parity bytes equal 0xFF, no buffer access occurs and `failed` stays low, whatever the syndrome and status are. `done` pulses two cycles after the start edge.
- R3: When the syndrome is zero on a sector that is not erased, no buffer access occurs, `failed` stays low and `done` pulses two cycles after the start edge.
- R4: The correction state is read from bits 11:8 of the status word. State 0 produces no access and no failure, and finishes in two cycles.
- R5: State 1 (five or more errors) and any state from 4 to 15 set `failed` and cause no buffer access. The block finishes in two cycles.
- R6: In states 2 and 3, bits 17:16 of the status word hold the number of entries minus one. Entries are applied in index order. Entries 0 and 1 come from bits 9:0 and 25:16 of location pair A and from bits 7:0 and 23:16 of value pair A. Entries 2 and 3 come from the same fields of pair B.
- R7: The buffer offset of an entry is 519 minus its 10-bit location. An entry is applied only when that offset is between 0 and 511. Any other entry is skipped without a buffer access.
- R8: An applied entry takes one read cycle and then one write cycle to the same offset. Read data is returned the cycle after the read enable, and the byte written is that data XOR the entry's value.
- R9: In the correction states, `done` is a one-cycle pulse that comes 2 + 2·applied + skipped cycles after the start edge.
- R10: `fixedCount` equals the number of entries applied, and `failed` is low in the correction states. Both hold their values until the next start.
- R11: A start pulse that arrives while a run is in progress is ignored and does not change the run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request that captures the decoder outcome |
| parityBytes | input | 80 | Ten stored parity bytes |
| syndromeNonzero | input | 1 | High when any syndrome word is nonzero |
| statusWord | input | 32 | Decoder status; state at 11:8, entry count minus one at 17:16 |
| errAddrPairA | input | 32 | Locations of entries 0 (9:0) and 1 (25:16) |
| errAddrPairB | input | 32 | Locations of entries 2 (9:0) and 3 (25:16) |
| errValPairA | input | 32 | Values of entries 0 (7:0) and 1 (23:16) |
| errValPairB | input | 32 | Values of entries 2 (7:0) and 3 (23:16) |
| bufRdData | input | 8 | Buffer read data, one cycle after the read enable |
| bufAddr | output | 9 | Buffer byte offset |
| bufRdEn | output | 1 | Buffer read enable |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrData | output | 8 | Corrected byte to write |
| done | output | 1 | One-cycle completion pulse |
| fixedCount | output | 3 | Number of bytes repaired in the last run |
| failed | output | 1 | Last run reported an uncorrectable sector |

## Verification
The erased-sector test and the failure-state decode are both evaluated in the same decision cycle. The sweep therefore pairs all-0xFF parity with state 1 and with states 4 to 15, and expects no failure and no buffer access, because the erased test has priority. Entries that share one offset bring a write and the following read to the same byte in back-to-back cycles. The bench models the buffer and checks that the second entry XORs on top of the first.

// File: rtl/eccFixPkg.sv
package eccFixPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD,
    ST_WR,
    ST_FIN
  } fixState_t;

  typedef struct packed {
    logic capture;
    logic setFail;
    logic incIdx;
    logic applyWr;
  } fixStrobe_t;
endpackage

// File: rtl/eccFixDp.sv
module eccFixDp #(
  parameter int SECTOR   = 512,
  parameter int PAR_N    = 10,
  parameter int ADDR_W   = 10,
  parameter int VAL_W    = 8,
  parameter int NUM_ERR  = 4,
  parameter int HALF     = 16,
  localparam int BUF_W   = $clog2(SECTOR),
  localparam int OFFS_W  = ADDR_W + 1,
  localparam int IDX_W   = $clog2(NUM_ERR),
  localparam int CNT_W   = $clog2(NUM_ERR + 1),
  localparam int PAIRS   = NUM_ERR / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  eccFixPkg::fixStrobe_t  strobe,
  input  logic [PAR_N*8-1:0]     parityBytes,
  input  logic                   syndromeNonzero,
  input  logic [31:0]            statusWord,
  input  logic [2*HALF-1:0]      errAddrPairA,
  input  logic [2*HALF-1:0]      errAddrPairB,
  input  logic [2*HALF-1:0]      errValPairA,
  input  logic [2*HALF-1:0]      errValPairB,
  input  logic [VAL_W-1:0]       bufRdData,
  output logic                   isErased,
  output logic                   synZero,
  output logic [3:0]             stateCode,
  output logic                   lastIdx,
  output logic                   curHit,
  output logic [BUF_W-1:0]       bufAddr,
  output logic [VAL_W-1:0]       bufWrData,
  output logic [CNT_W-1:0]       fixedCount,
  output logic                   failed
);
  logic               erasedQ, synQ;
  logic [3:0]         stateQ;
  logic [IDX_W-1:0]   cntQ, idxQ;
  logic [2*HALF-1:0]  addrPairQ [PAIRS];
  logic [2*HALF-1:0]  valPairQ  [PAIRS];
  logic [ADDR_W-1:0]  entAddr   [NUM_ERR];
  logic [VAL_W-1:0]   entVal    [NUM_ERR];
  logic [OFFS_W-1:0]  offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      erasedQ    <= 1'b0;
      synQ       <= 1'b0;
      stateQ     <= '0;
      cntQ       <= '0;
      idxQ       <= '0;
      fixedCount <= '0;
      failed     <= 1'b0;
      addrPairQ  <= '{default: '0};
      valPairQ   <= '{default: '0};
    end else begin
      if (strobe.capture) begin
        erasedQ      <= &parityBytes;
        synQ         <= syndromeNonzero;
        stateQ       <= statusWord[11:8];
        cntQ         <= statusWord[16 +: IDX_W];
        idxQ         <= '0;
        fixedCount   <= '0;
        failed       <= 1'b0;
        addrPairQ[0] <= errAddrPairA;
        addrPairQ[1] <= errAddrPairB;
        valPairQ[0]  <= errValPairA;
        valPairQ[1]  <= errValPairB;
      end
      if (strobe.setFail) failed <= 1'b1;
      if (strobe.incIdx) idxQ <= idxQ + 1'b1;
      if (strobe.applyWr) fixedCount <= fixedCount + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_entry
    assign entAddr[g] = addrPairQ[g / 2][(g % 2) * HALF +: ADDR_W];
    assign entVal[g]  = valPairQ[g / 2][(g % 2) * HALF +: VAL_W];
  end

  assign offset    = OFFS_W'(SECTOR + 7) - {1'b0, entAddr[idxQ]};
  assign curHit    = offset < OFFS_W'(SECTOR);
  assign bufAddr   = offset[BUF_W-1:0];
  assign bufWrData = bufRdData ^ entVal[idxQ];
  assign isErased  = erasedQ;
  assign synZero   = !synQ;
  assign stateCode = stateQ;
  assign lastIdx   = idxQ == cntQ;
endmodule

// File: rtl/eccFixCtl.sv
module eccFixCtl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   isErased,
  input  logic                   synZero,
  input  logic [3:0]             stateCode,
  input  logic                   lastIdx,
  input  logic                   curHit,
  output eccFixPkg::fixStrobe_t  strobe,
  output logic                   bufRdEn,
  output logic                   bufWrEn,
  output logic                   done
);
  import eccFixPkg::*;
  fixState_t stQ, stD;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  always_comb begin
    stD     = stQ;
    strobe  = '0;
    bufRdEn = 1'b0;
    bufWrEn = 1'b0;
    done    = 1'b0;
    unique case (stQ)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stD = ST_EVAL;
      end
      ST_EVAL: begin
        if (isErased || synZero || stateCode == 4'd0) begin
          stD = ST_FIN;
        end else if (stateCode == 4'd2 || stateCode == 4'd3) begin
          stD = ST_RD;
        end else begin
          strobe.setFail = 1'b1;
          stD = ST_FIN;
        end
      end
      ST_RD: begin
        if (curHit) begin
          bufRdEn = 1'b1;
          stD = ST_WR;
        end else if (lastIdx) begin
          stD = ST_FIN;
        end else begin
          strobe.incIdx = 1'b1;
        end
      end
      ST_WR: begin
        bufWrEn = 1'b1;
        strobe.applyWr = 1'b1;
        if (lastIdx) stD = ST_FIN;
        else begin
          strobe.incIdx = 1'b1;
          stD = ST_RD;
        end
      end
      ST_FIN: begin
        done = 1'b1;
        stD = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/eccFixApply.sv
module eccFixApply #(
  parameter int SECTOR  = 512,
  parameter int PAR_N   = 10,
  parameter int ADDR_W  = 10,
  parameter int VAL_W   = 8,
  parameter int NUM_ERR = 4,
  parameter int HALF    = 16,
  localparam int BUF_W  = $clog2(SECTOR),
  localparam int CNT_W  = $clog2(NUM_ERR + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PAR_N*8-1:0] parityBytes,
  input  logic               syndromeNonzero,
  input  logic [31:0]        statusWord,
  input  logic [2*HALF-1:0]  errAddrPairA,
  input  logic [2*HALF-1:0]  errAddrPairB,
  input  logic [2*HALF-1:0]  errValPairA,
  input  logic [2*HALF-1:0]  errValPairB,
  input  logic [VAL_W-1:0]   bufRdData,
  output logic [BUF_W-1:0]   bufAddr,
  output logic               bufRdEn,
  output logic               bufWrEn,
  output logic [VAL_W-1:0]   bufWrData,
  output logic               done,
  output logic [CNT_W-1:0]   fixedCount,
  output logic               failed
);
  eccFixPkg::fixStrobe_t strobe;
  logic       isErased, synZero, lastIdx, curHit;
  logic [3:0] stateCode;

  eccFixCtl i_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .isErased(isErased), .synZero(synZero), .stateCode(stateCode),
    .lastIdx(lastIdx), .curHit(curHit), .strobe(strobe),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .done(done)
  );

  eccFixDp #(
    .SECTOR(SECTOR), .PAR_N(PAR_N), .ADDR_W(ADDR_W),
    .VAL_W(VAL_W), .NUM_ERR(NUM_ERR), .HALF(HALF)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .parityBytes(parityBytes), .syndromeNonzero(syndromeNonzero),
    .statusWord(statusWord),
    .errAddrPairA(errAddrPairA), .errAddrPairB(errAddrPairB),
    .errValPairA(errValPairA), .errValPairB(errValPairB),
    .bufRdData(bufRdData),
    .isErased(isErased), .synZero(synZero), .stateCode(stateCode),
    .lastIdx(lastIdx), .curHit(curHit), .bufAddr(bufAddr),
    .bufWrData(bufWrData), .fixedCount(fixedCount), .failed(failed)
  );
endmodule

// File: rtl/eccFixApplyChk.sv
module eccFixApplyChk #(
  parameter int BUF_W = 9,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             bufRdEn,
  input logic             bufWrEn,
  input logic [BUF_W-1:0] bufAddr,
  input logic             done,
  input logic [CNT_W-1:0] fixedCount,
  input logic             failed
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(bufRdEn && bufWrEn)); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(bufRdEn)); // R8
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |=> bufWrEn && $stable(bufAddr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_FAIL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> !bufRdEn && !bufWrEn); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> fixedCount == $past(fixedCount) + 1'b1); // R10
endmodule

bind eccFixApply eccFixApplyChk #(.BUF_W(BUF_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_eccFixApply.sv
module test_eccFixApply;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [79:0] parityBytes = '1;
  logic        syndromeNonzero = 1'b0;
  logic [31:0] statusWord = '0;
  logic [31:0] errAddrPairA = '0, errAddrPairB = '0;
  logic [31:0] errValPairA = '0, errValPairB = '0;
  logic [7:0]  bufRdData;
  logic [8:0]  bufAddr;
  logic        bufRdEn, bufWrEn, done, failed;
  logic [7:0]  bufWrData;
  logic [2:0]  fixedCount;

  int total = 0, fails = 0, accesses = 0;
  logic [7:0] mem [512];
  logic [7:0] expMem [512];
  logic [7:0] rdQ = '0;

  always #2 clk = ~clk;
  assign bufRdData = rdQ;

  eccFixApply i_eccFixApply (.*);

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
      expMem[i] = mem[i];
    end
  end

  always @(posedge clk) begin
    if (bufRdEn) rdQ <= mem[bufAddr];
    if (bufWrEn) mem[bufAddr] <= bufWrData;
    if (bufRdEn || bufWrEn) accesses <= accesses + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pickAddr(input int s, input int j);
    case (s)
      0: case (j) 0: return 10'd8; 1: return 10'd519; 2: return 10'd100; default: return 10'd300; endcase
      1: case (j) 0: return 10'd7; 1: return 10'd263; 2: return 10'd1023; default: return 10'd520; endcase
      default: case (j) 0: return 10'd200; 1: return 10'd200; 2: return 10'd0; default: return 10'd9; endcase
    endcase
  endfunction

  task automatic runCase(input bit er, input bit syn, input int st, input int cnt,
                         input int s, input bit midStart);
    logic [7:0] v [4];
    int edges, expLat, applied, skipped, base, memBad;
    bit fixing;
    for (int j = 0; j < 4; j++) v[j] = 8'(8'h11 * (j + 1) + s + st);
    @(negedge clk);
    parityBytes = '1;
    if (!er) parityBytes[8 * (s + 3) +: 8] = 8'hFE;
    syndromeNonzero = syn;
    statusWord = {14'h2A5, 2'(cnt), 4'h9, 4'(st), 8'h5C};
    errAddrPairA = {6'h3F, pickAddr(s, 1), 6'h2A, pickAddr(s, 0)};
    errAddrPairB = {6'h15, pickAddr(s, 3), 6'h3F, pickAddr(s, 2)};
    errValPairA = {8'hC3, v[1], 8'h5A, v[0]};
    errValPairB = {8'h7E, v[3], 8'hA5, v[2]};
    base = accesses;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    if (midStart) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      edges++;
    end
    while (!done && edges < 40) begin
      @(negedge clk);
      edges++;
    end
    fixing = !er && syn && (st == 2 || st == 3);
    applied = 0;
    skipped = 0;
    if (fixing) begin
      for (int j = 0; j <= cnt; j++) begin
        int off = 519 - int'(pickAddr(s, j));
        if (off >= 0 && off < 512) begin
          expMem[off] = expMem[off] ^ v[j];
          applied++;
        end else skipped++;
      end
    end
    expLat = fixing ? 2 + 2 * applied + skipped : 2;
    check("R9 done latency", edges, expLat);
    @(negedge clk);
    check("R9 done single pulse", int'(done), 0);
    check("R10 fixedCount", int'(fixedCount), applied);
    check("R5 failed flag", int'(failed), (!er && syn && (st == 1 || st > 3)) ? 1 : 0);
    if (!fixing) check("R2 R3 R4 no access", accesses - base, 0);
    else check("R7 R8 access count", accesses - base, 2 * applied);
    memBad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== expMem[i]) memBad++;
    check("R6 R7 R8 buffer contents", memBad, 0);
    repeat (2) @(negedge clk);
    check("R10 results held", int'(fixedCount), applied);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 rd/wr in reset", int'(bufRdEn | bufWrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 failed after reset", int'(failed), 0);
    check("R1 fixedCount after reset", int'(fixedCount), 0);
    check("R1 done after reset", int'(done), 0);
    for (int er = 0; er < 2; er++)
      for (int syn = 0; syn < 2; syn++)
        for (int st = 0; st < 16; st++)
          for (int cnt = 0; cnt < 4; cnt++)
            for (int s = 0; s < 3; s++)
              if (st <= 5 || st == 15 || s == 0)
                runCase(er[0], syn[0], st, cnt, s, 1'b0);
    // R2 erased priority over failure state, R11 start ignored mid-run
    runCase(1'b1, 1'b1, 1, 3, 0, 1'b1);
    runCase(1'b0, 1'b1, 2, 3, 0, 1'b1);
    runCase(1'b0, 1'b1, 3, 3, 2, 1'b1);
    runCase(1'b0, 1'b1, 1, 2, 1, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule